// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block sits between an internal single-word request bus with a valid/ready handshake and an external asynchronous static RAM. The RAM has a 17-bit address, an 8-bit data bus and three active-low strobes: chip select, output enable and write enable. The controller accepts one read or write at a time and drives the address and the strobes through a fixed sequence of phases. It drives the write data together with a tristate enable, and it registers the read data.

Every phase length is a parameter counted in clock cycles, with a minimum of one. The integrator sets these lengths from the clock period and the RAM speed grade: access time for reads, address-to-write-end time and pulse width for writes, and output release time for turnaround. Whenever no request is in progress, the chip select stays high so that the RAM rests in standby.

The read sequence is access, then capture, then idle. The write sequence is setup, then pulse, then release, then idle. A turnaround phase with all strobes high comes before the write setup whenever the previous transaction was a read.

Top module: `sram_ctl`

## Requirements
- R1: After reset, and whenever no transaction is in progress, chip select, output enable and write enable are all high, the data drive enable is low and request ready is high.
- R2: An accepted read keeps chip select and output enable low, with write enable high, for exactly RD_CYC cycles. The address is held at the requested value throughout. The next cycle has chip select low and output enable high, and the block is idle in the cycle after that.
- R3: The read data returned equals the value the RAM presents on the data input at the clock edge that ends the access phase. Response valid is high for exactly one cycle per read, in the cycle that follows the access phase.
- R4: An accepted write has SETUP_CYC cycles with chip select low and both output enable and write enable high. These are followed by PULSE_CYC cycles with write enable low and then one release cycle with write enable high and chip select still low. The block is then idle.
- R5: During a write, the address and the data output do not change from the first setup cycle to the end of the release cycle. Each completed write stores its data at its address in the RAM.
- R6: The data drive enable is high only while output enable is high. It is high for the whole write-enable low pulse and low in the cycle in which write enable rises.
- R7: A write whose previous transaction was a read is preceded by exactly TURN_CYC cycles with all strobes high and the drive enable low. A write that follows a write, or that is the first transaction after reset, has no such cycles.
- R8: Request ready is low in every cycle of a transaction. A request with valid low starts nothing: chip select and write enable remain high.
- R9: Write enable is never low unless chip select is low, and output enable is high throughout every write.
- R10: Output enable never falls in a cycle that directly follows a cycle with the drive enable high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle pulse carrying read data |
| rsp_rdata | output | 8 | Read data |
| sram_addr | output | 17 | RAM address |
| sram_ce_n | output | 1 | RAM chip select, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_we_n | output | 1 | RAM write enable, active low |
| sram_dq_out | output | 8 | Data toward the RAM |
| sram_dq_oe | output | 1 | Tristate enable for sram_dq_out at the pad |
| sram_dq_in | input | 8 | Data from the RAM pad |

## Verification
The assertions assume that request fields are sampled only on the accepting edge. They also assume the RAM's data input is meaningful only while output enable is low. The checks on strobe, address and data stability therefore refer only to the controller's own outputs. The bench drives each request at a falling edge, only when ready is high, and drops valid right after acceptance. It changes the request fields freely while valid is low, which exercises the rule that such inputs are ignored. The RAM model drives data only during a read, keeps driving for one cycle after output enable rises, and commits a write only when write enable rises. A controller with a missing turnaround, an early data release or an unstable address therefore shows up as contention or as wrong memory contents.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RD_ACC,
        PH_RD_CAP,
        PH_TURN,
        PH_WR_SETUP,
        PH_WR_PULSE,
        PH_WR_REL
    } phase_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic drive;
    } strobe_t;

    // Strobe levels seen by the RAM in each phase.
    function automatic strobe_t strobes_for(input phase_e p);
        strobe_t s;
        s = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
        case (p)
            PH_RD_ACC:   s = '{ce_n: 1'b0, oe_n: 1'b0, we_n: 1'b1, drive: 1'b0};
            PH_RD_CAP:   s = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
            PH_WR_SETUP: s = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, drive: 1'b1};
            PH_WR_PULSE: s = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b0, drive: 1'b1};
            PH_WR_REL:   s = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
            default:     s = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
        endcase
        return s;
    endfunction

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    function automatic int cnt_width(input int maxc);
        return (maxc < 2) ? 1 : $clog2(maxc);
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

    AST_TIMER_HOLDS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!$past(load) && $past(cnt) == '0) |-> cnt == '0); // R4

endmodule

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
    import sram_ctl_pkg::*;
#(
    parameter int RD_CYC    = 2,
    parameter int SETUP_CYC = 1,
    parameter int PULSE_CYC = 2,
    parameter int TURN_CYC  = 1,
    parameter int CW        = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_fire,
    input  logic          req_write,
    input  logic          tmr_done,
    output phase_e        phase,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic          capture,
    output logic          idle,
    output logic          rsp_pulse
);
    phase_e state, nxt;
    logic   last_rd;

    always_comb begin
        nxt = state;
        case (state)
            PH_IDLE:
                if (req_fire)
                    nxt = !req_write ? PH_RD_ACC : (last_rd ? PH_TURN : PH_WR_SETUP);
            PH_RD_ACC:   if (tmr_done) nxt = PH_RD_CAP;
            PH_RD_CAP:   nxt = PH_IDLE;
            PH_TURN:     if (tmr_done) nxt = PH_WR_SETUP;
            PH_WR_SETUP: if (tmr_done) nxt = PH_WR_PULSE;
            PH_WR_PULSE: if (tmr_done) nxt = PH_WR_REL;
            PH_WR_REL:   nxt = PH_IDLE;
            default:     nxt = PH_IDLE;
        endcase
    end

    always_comb begin
        case (nxt)
            PH_RD_ACC:   tmr_val = CW'(RD_CYC - 1);
            PH_TURN:     tmr_val = CW'(TURN_CYC - 1);
            PH_WR_SETUP: tmr_val = CW'(SETUP_CYC - 1);
            PH_WR_PULSE: tmr_val = CW'(PULSE_CYC - 1);
            default:     tmr_val = '0;
        endcase
    end

    assign tmr_load  = (nxt != state);
    assign capture   = (state == PH_RD_ACC) && tmr_done;
    assign idle      = (state == PH_IDLE);
    assign rsp_pulse = (state == PH_RD_CAP);
    assign phase     = state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= PH_IDLE;
            last_rd <= 1'b0;
        end else begin
            state <= nxt;
            if (state == PH_RD_CAP)
                last_rd <= 1'b1;
            else if (state == PH_WR_SETUP)
                last_rd <= 1'b0;
        end
    end

    AST_CAP_THEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        state == PH_RD_CAP |=> state == PH_IDLE); // R2
    AST_REL_THEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        state == PH_WR_REL |=> state == PH_IDLE); // R4
    AST_TURN_ONLY_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        $rose(state == PH_TURN) |-> $past(last_rd)); // R7

endmodule

// File: rtl/sram_ctl_datapath.sv
module sram_ctl_datapath
    import sram_ctl_pkg::*;
#(
    parameter int AW = 17,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_fire,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          capture,
    input  phase_e        phase,
    input  logic [DW-1:0] dq_in,
    output logic [AW-1:0] sram_addr,
    output logic          ce_n,
    output logic          oe_n,
    output logic          we_n,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe,
    output logic [DW-1:0] rdata
);
    strobe_t       stb;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (req_fire) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (capture)
                rdata_q <= dq_in;
        end
    end

    assign stb       = strobes_for(phase);
    assign ce_n      = stb.ce_n;
    assign oe_n      = stb.oe_n;
    assign we_n      = stb.we_n;
    assign dq_oe     = stb.drive;
    assign sram_addr = addr_q;
    assign dq_out    = wdata_q;
    assign rdata     = rdata_q;

    AST_ADDR_STABLE_SELECTED: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && $past(!ce_n)) |-> $stable(addr_q)); // R5
    AST_WDATA_STABLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        (!we_n && $past(!we_n)) |-> $stable(wdata_q)); // R5

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int DATA_W    = 8,
    parameter int RD_CYC    = 2,
    parameter int SETUP_CYC = 1,
    parameter int PULSE_CYC = 2,
    parameter int TURN_CYC  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in
);
    localparam int MAXC = max4(RD_CYC, SETUP_CYC, PULSE_CYC, TURN_CYC);
    localparam int CW   = cnt_width(MAXC);

    phase_e        phase;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_done;
    logic          capture;
    logic          idle;
    logic          req_fire;

    assign req_ready = idle;
    assign req_fire  = req_valid && idle;

    sram_phase_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sram_ctl_fsm #(
        .RD_CYC    (RD_CYC),
        .SETUP_CYC (SETUP_CYC),
        .PULSE_CYC (PULSE_CYC),
        .TURN_CYC  (TURN_CYC),
        .CW        (CW)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_fire  (req_fire),
        .req_write (req_write),
        .tmr_done  (tmr_done),
        .phase     (phase),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .capture   (capture),
        .idle      (idle),
        .rsp_pulse (rsp_valid)
    );

    sram_ctl_datapath #(.AW(ADDR_W), .DW(DATA_W)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .req_fire  (req_fire),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .capture   (capture),
        .phase     (phase),
        .dq_in     (sram_dq_in),
        .sram_addr (sram_addr),
        .ce_n      (sram_ce_n),
        .oe_n      (sram_oe_n),
        .we_n      (sram_we_n),
        .dq_out    (sram_dq_out),
        .dq_oe     (sram_dq_oe),
        .rdata     (rsp_rdata)
    );

    AST_READY_DESELECTED: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe)); // R1
    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R3
    AST_RSP_BUSY: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready); // R8
    AST_DRIVE_OE_HIGH: assert property (@(posedge clk) disable iff (rst)
        sram_dq_oe |-> sram_oe_n); // R6
    AST_DRIVE_OFF_WE_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_we_n) |-> !sram_dq_oe); // R6
    AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |-> (!sram_ce_n && sram_oe_n)); // R9
    AST_OE_FALL_BUS_FREE: assert property (@(posedge clk) disable iff (rst)
        $fell(sram_oe_n) |-> !$past(sram_dq_oe)); // R10

endmodule

// File: tb/sram_ctl_test.sv
module sram_ctl_test;
    localparam int AW = 17;
    localparam int DW = 8;
    localparam int RD_CYC = 2, SETUP_CYC = 1, PULSE_CYC = 2, TURN_CYC = 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] sram_addr;
    logic          sram_ce_n, sram_oe_n, sram_we_n;
    logic [DW-1:0] sram_dq_out;
    logic          sram_dq_oe;
    logic [DW-1:0] sram_dq_in = '0;

    int checks = 0;
    int errors = 0;
    bit last_rd = 1'b0;

    logic [DW-1:0] ram_mem [int];
    logic [DW-1:0] exp_mem [int];

    always #5 clk = ~clk;

    sram_ctl #(
        .ADDR_W(AW), .DATA_W(DW), .RD_CYC(RD_CYC),
        .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .TURN_CYC(TURN_CYC)
    ) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sram_addr(sram_addr),
        .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
        .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
    );

    function automatic logic [DW-1:0] init_val(input logic [AW-1:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a);
        return exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : init_val(a);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // RAM model: drives data during reads (and one cycle after OE rises),
    // commits writes when the CE/WE overlap ends, flags protocol faults.
    bit            wr_act = 1'b0;
    logic [AW-1:0] wr_a;
    logic [DW-1:0] wr_d;
    bit            drv_prev = 1'b0;
    always @(negedge clk) begin
        bit rd_now, act_now;
        if (!rst) begin
            rd_now  = !sram_ce_n && !sram_oe_n && sram_we_n;
            act_now = !sram_ce_n && !sram_we_n;
            if ((rd_now || drv_prev) && sram_dq_oe)
                chk(1'b0, "R10", "bus contention", 1, 0);
            if (act_now) begin
                if (!sram_dq_oe)
                    chk(1'b0, "R6", "data not driven in pulse", 0, 1);
                if (wr_act && (wr_a != sram_addr))
                    chk(1'b0, "R5", "address moved in pulse", int'(sram_addr), int'(wr_a));
                if (wr_act && (wr_d != sram_dq_out))
                    chk(1'b0, "R5", "data moved in pulse", int'(sram_dq_out), int'(wr_d));
                wr_a = sram_addr;
                wr_d = sram_dq_out;
            end else if (wr_act) begin
                ram_mem[int'(wr_a)] = wr_d;
            end
            wr_act   = act_now;
            drv_prev = rd_now;
            sram_dq_in <= rd_now ? (ram_mem.exists(int'(sram_addr)) ?
                          ram_mem[int'(sram_addr)] : init_val(sram_addr)) : 8'h00;
        end
    end

    task automatic issue(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_addr  = AW'($urandom);
        req_wdata = DW'($urandom);
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        int n_turn, n_setup, n_pulse;
        bit rdy_bad, addr_bad;
        n_turn = 0; n_setup = 0; n_pulse = 0; rdy_bad = 0; addr_bad = 0;
        issue(1'b1, a, d);
        while (sram_ce_n && n_turn < 40) begin
            if (req_ready || !sram_oe_n || !sram_we_n || sram_dq_oe) rdy_bad = 1;
            n_turn++; @(negedge clk);
        end
        while (!sram_ce_n && sram_we_n && n_setup < 40) begin
            if (req_ready || !sram_oe_n) rdy_bad = 1;
            if (sram_addr != a || sram_dq_out != d) addr_bad = 1;
            n_setup++; @(negedge clk);
        end
        while (!sram_we_n && n_pulse < 40) begin
            if (req_ready) rdy_bad = 1;
            n_pulse++; @(negedge clk);
        end
        chk(n_turn == (last_rd ? TURN_CYC : 0), "R7", "turnaround cycles", n_turn,
            last_rd ? TURN_CYC : 0);
        chk(n_setup == SETUP_CYC, "R4", "setup cycles", n_setup, SETUP_CYC);
        chk(n_pulse == PULSE_CYC, "R4", "pulse cycles", n_pulse, PULSE_CYC);
        chk(!addr_bad, "R5", "address/data at setup", int'(sram_addr), int'(a));
        chk(!sram_ce_n && sram_we_n && !sram_dq_oe && !req_ready, "R6",
            "release cycle strobes", int'({sram_ce_n, sram_we_n, sram_dq_oe}), 3'b010);
        chk(sram_addr == a, "R5", "address in release", int'(sram_addr), int'(a));
        @(negedge clk);
        chk(!rdy_bad, "R8", "ready low during write", int'(rdy_bad), 0);
        chk(req_ready && sram_ce_n && sram_we_n && sram_oe_n, "R1", "idle after write",
            int'({req_ready, sram_ce_n}), 3);
        exp_mem[int'(a)] = d;
        last_rd = 1'b0;
    endtask

    task automatic do_read(input logic [AW-1:0] a);
        int n_acc;
        bit bad;
        logic [DW-1:0] e;
        n_acc = 0; bad = 0;
        e = exp_read(a);
        issue(1'b0, a, 8'h00);
        while (!sram_oe_n && n_acc < 40) begin
            if (sram_ce_n || !sram_we_n || sram_addr != a || req_ready || rsp_valid) bad = 1;
            n_acc++; @(negedge clk);
        end
        chk(n_acc == RD_CYC, "R2", "access cycles", n_acc, RD_CYC);
        chk(!bad, "R2", "strobes/address during access", int'(bad), 0);
        chk(!sram_ce_n && sram_oe_n && !req_ready, "R2", "capture cycle strobes",
            int'({sram_ce_n, sram_oe_n}), 1);
        chk(rsp_valid == 1'b1, "R3", "response valid", int'(rsp_valid), 1);
        chk(rsp_rdata == e, "R3", "read data", int'(rsp_rdata), int'(e));
        @(negedge clk);
        chk(!rsp_valid && req_ready && sram_ce_n, "R3", "single response pulse",
            int'(rsp_valid), 0);
        last_rd = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "R1", "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [AW-1:0] pool [0:17];
        void'($urandom(32'd24681));
        repeat (4) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe && req_ready && !rsp_valid,
            "R1", "reset state", int'({sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe}), 4'b1110);

        // R8: valid low with busy fields must start nothing
        for (int i = 0; i < 6; i++) begin
            req_write = 1'b1; req_addr = AW'($urandom); req_wdata = DW'($urandom);
            @(negedge clk);
            chk(sram_ce_n && sram_we_n && !rsp_valid, "R8", "valid low ignored",
                int'({sram_ce_n, sram_we_n}), 3);
        end

        // Directed corners: first write (no turnaround), extreme addresses/data
        do_write(17'h00000, 8'hFF);
        do_write(17'h1FFFF, 8'h00);                 // R7 write after write
        do_read(17'h1FFFF);
        do_write(17'h00000, 8'h5A);                 // R7 write after read
        do_read(17'h00000);
        do_read(17'h0ABCD);                         // never written
        do_read(17'h1FFFF);

        for (int i = 0; i < 16; i++) pool[i] = AW'(17'h00100 + i);
        pool[16] = 17'h00000;
        pool[17] = 17'h1FFFF;
        for (int i = 0; i < 400; i++) begin
            logic [AW-1:0] a;
            a = pool[$urandom_range(0, 17)];
            if ($urandom_range(0, 1) == 1) do_write(a, DW'($urandom));
            else do_read(a);
            repeat ($urandom_range(0, 2)) @(negedge clk);
        end

        chk(1'b1, "R5", "memory model writes consistent", 0, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule